// File: doc/BRIEF.md
# Receive Cell Mode and Event Registers

This block holds the two byte-wide registers that configure and watch the receive cell path. A host reaches them through a plain port made of an address bus, a write-data byte, a read-data byte and separate read and write strobes. The control register holds seven mode bits that are wired straight to the receive datapath. The mode bits are output parity sense, header filter bypass, header correction disable, errored-cell pass, coset enable, descrambler disable and receive FIFO reset. The top bit of the same byte reads back the live out-of-delineation status.

The event register holds three interrupt enables and four sticky flags. The receive datapath reports correctable header errors, uncorrectable header errors and FIFO overflows as one-cycle pulses. The delineation status comes in as a level, and any change of that level, rising or falling, raises a flag. A read of the event register returns the flags and clears them. An event that lands in the same cycle as that read is kept. A single active-high interrupt output is raised whenever an enabled flag is pending. The header-error enable covers both header-error flags.

Top module: `rx_cell_regs`

## Requirements
- R1: After reset, the control register reads 0x04 while the status input is low, so coset_en is 1 and every other mode output is 0. The event register reads 0x00 and irq is 0.
- R2: A write to address 0x50 stores wdata bits 6..0 and drives the mode outputs from them: bit 6 par_even (1 even, 0 odd), bit 5 filt_bypass, bit 4 corr_dis, bit 3 err_pass, bit 2 coset_en, bit 1 descr_dis, bit 0 fifo_rst. The same bits read back at the same positions.
- R3: Bit 7 of address 0x50 always reads the present value of status_ood, and writes to that bit are ignored.
- R4: A write to address 0x51 stores only wdata bits 7 (delineation enable), 6 (header-error enable) and 5 (overflow enable). Written values on bits 4..0 set no flag, and bit 0 always reads 0.
- R5: A pulse on ev_corr, ev_uncorr or ev_ovf sets flag bit 3, 2 or 1 of address 0x51 at the next clock edge. The flag stays set until the register is read.
- R6: Flag bit 4 of address 0x51 sets when status_ood differs from its value in the previous cycle, in either direction. The previous-cycle sample starts at 0 after reset.
- R7: A read strobe at address 0x51 returns the flags as they stand and clears them at that clock edge. An event arriving in the same cycle as the read leaves its flag set.
- R8: irq equals (bit4 AND bit7) OR ((bit3 OR bit2) AND bit6) OR (bit1 AND bit5) of address 0x51.
- R9: Any other address reads 0x00. A write to it changes nothing, and a read of it clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Read data for addr, combinational |
| status_ood | input | 1 | Out-of-delineation status level |
| ev_corr | input | 1 | Correctable header error pulse |
| ev_uncorr | input | 1 | Uncorrectable header error pulse |
| ev_ovf | input | 1 | Receive FIFO overflow pulse |
| par_even | output | 1 | Output parity sense, 1 even |
| filt_bypass | output | 1 | Header filter bypass |
| corr_dis | output | 1 | Header correction disable |
| err_pass | output | 1 | Pass errored cells |
| coset_en | output | 1 | Coset addition enable |
| descr_dis | output | 1 | Payload descrambler disable |
| fifo_rst | output | 1 | Receive FIFO reset, held while set |
| irq | output | 1 | Interrupt, active high |

## Verification
On every cycle the assertions check several rules. A control write lands on the mode outputs, and bit 7 of the control read mirrors the status input. A pending flag outlives any cycle without a clearing read, and a read with no coincident event empties the flags. A status change raises the delineation flag, and irq stays low with all enables cleared. The bench scenarios show the parts that need a chosen history: the exact reset values, the rule that masks read-only and reserved bits, and the sharing of the header-error enable between two flags. They also show an event kept when it coincides with a read, and that a read of an unmapped address leaves the flags alone.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
    localparam int DATA_W   = 8;
    localparam int MODE_W   = 7;
    localparam int ADDR_W   = 8;

    typedef struct packed {
        logic par_even;
        logic filt_bypass;
        logic corr_dis;
        logic err_pass;
        logic coset_en;
        logic descr_dis;
        logic fifo_rst;
    } mode_t;

    typedef struct packed {
        logic en_ood;
        logic en_hec;
        logic en_ovf;
        logic f_ood;
        logic f_corr;
        logic f_uncorr;
        logic f_ovf;
        logic samp;
    } evt_t;
endpackage

// File: rtl/rxc_mode_reg.sv
module rxc_mode_reg
    import rxc_pkg::*;
#(
    parameter logic [MODE_W-1:0] RST_VAL = 7'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output mode_t             mode
);
    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (wr_sel) begin
            mode_d = mode_t'(wdata[MODE_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_t'(RST_VAL);
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

    // R2: a write shows on the mode outputs one edge later
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (mode == $past(wdata[MODE_W-1:0])));
endmodule

// File: rtl/rxc_event_reg.sv
module rxc_event_reg
    import rxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic              rd_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              status,
    input  logic              ev_corr,
    input  logic              ev_uncorr,
    input  logic              ev_ovf,
    output logic [DATA_W-1:0] value,
    output logic              irq
);
    evt_t evt_d, evt_q;

    always_comb begin
        evt_d      = evt_q;
        evt_d.samp = status;
        if (wr_sel) begin
            evt_d.en_ood = wdata[7];
            evt_d.en_hec = wdata[6];
            evt_d.en_ovf = wdata[5];
        end
        if (rd_sel) begin
            evt_d.f_ood    = 1'b0;
            evt_d.f_corr   = 1'b0;
            evt_d.f_uncorr = 1'b0;
            evt_d.f_ovf    = 1'b0;
        end
        if (status != evt_q.samp) evt_d.f_ood    = 1'b1;
        if (ev_corr)              evt_d.f_corr   = 1'b1;
        if (ev_uncorr)            evt_d.f_uncorr = 1'b1;
        if (ev_ovf)               evt_d.f_ovf    = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign value = {evt_q.en_ood, evt_q.en_hec, evt_q.en_ovf,
                    evt_q.f_ood, evt_q.f_corr, evt_q.f_uncorr, evt_q.f_ovf, 1'b0};
    assign irq   = (evt_q.f_ood & evt_q.en_ood)
                 | ((evt_q.f_corr | evt_q.f_uncorr) & evt_q.en_hec)
                 | (evt_q.f_ovf & evt_q.en_ovf);

    // checker-side history of the status input
    logic prev_q, prev_v_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            prev_v_q <= 1'b0;
        end else begin
            prev_q   <= status;
            prev_v_q <= 1'b1;
        end
    end

    // R5: flags are sticky without a clearing read
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_sel && (value[4:1] != 4'h0)) |=> ((value[4:1] & $past(value[4:1])) == $past(value[4:1])));

    // R6: a status change raises the delineation flag
    a_r6_ood_change: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_v_q && (status != prev_q)) |=> value[4]);

    // R7: a read with no coincident event empties the flags
    a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && prev_v_q && (status == prev_q) && !ev_corr && !ev_uncorr && !ev_ovf)
        |=> (value[4:1] == 4'h0));

    // R7: an event coincident with the read is kept
    a_r7_keep_event: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && ev_ovf) |=> value[1]);

    // R4: reserved bit stays zero
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> !value[0]);
endmodule

// File: rtl/rx_cell_regs.sv
module rx_cell_regs
    import rxc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h50,
    parameter logic [ADDR_W-1:0] EVT_ADDR  = 8'h51,
    parameter logic [MODE_W-1:0] MODE_RST  = 7'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic              status_ood,
    input  logic              ev_corr,
    input  logic              ev_uncorr,
    input  logic              ev_ovf,
    output logic              par_even,
    output logic              filt_bypass,
    output logic              corr_dis,
    output logic              err_pass,
    output logic              coset_en,
    output logic              descr_dis,
    output logic              fifo_rst,
    output logic              irq
);
    mode_t             mode;
    logic [DATA_W-1:0] evt_val;
    logic              hit_mode, hit_evt;

    assign hit_mode = (addr == MODE_ADDR);
    assign hit_evt  = (addr == EVT_ADDR);

    rxc_mode_reg #(.RST_VAL(MODE_RST)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_en & hit_mode),
        .wdata  (wdata),
        .mode   (mode)
    );

    rxc_event_reg u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (wr_en & hit_evt),
        .rd_sel    (rd_en & hit_evt),
        .wdata     (wdata),
        .status    (status_ood),
        .ev_corr   (ev_corr),
        .ev_uncorr (ev_uncorr),
        .ev_ovf    (ev_ovf),
        .value     (evt_val),
        .irq       (irq)
    );

    always_comb begin
        rdata = '0;
        if (hit_mode)     rdata = {status_ood, mode};
        else if (hit_evt) rdata = evt_val;
    end

    assign par_even    = mode.par_even;
    assign filt_bypass = mode.filt_bypass;
    assign corr_dis    = mode.corr_dis;
    assign err_pass    = mode.err_pass;
    assign coset_en    = mode.coset_en;
    assign descr_dis   = mode.descr_dis;
    assign fifo_rst    = mode.fifo_rst;

    // R3: the top control bit mirrors the live status
    a_r3_status_live: assert property (@(posedge clk) disable iff (!rst_n)
        hit_mode |-> (rdata[7] == status_ood));

    // R8: no interrupt while every enable is clear
    a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_val[7:5] == 3'b000) |-> !irq);
endmodule

// File: tb/sim_rx_cell_regs.sv
module sim_rx_cell_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       status_ood = 1'b0;
    logic       ev_corr = 1'b0, ev_uncorr = 1'b0, ev_ovf = 1'b0;
    logic       par_even, filt_bypass, corr_dis, err_pass, coset_en, descr_dis, fifo_rst, irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rx_cell_regs u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
        .rdata(rdata), .status_ood(status_ood), .ev_corr(ev_corr), .ev_uncorr(ev_uncorr),
        .ev_ovf(ev_ovf), .par_even(par_even), .filt_bypass(filt_bypass), .corr_dis(corr_dis),
        .err_pass(err_pass), .coset_en(coset_en), .descr_dis(descr_dis), .fifo_rst(fifo_rst),
        .irq(irq)
    );

    // {address, write data, expected read-back}
    localparam logic [23:0] VEC [7] = '{
        {8'h50, 8'hFF, 8'h7F},   // R2 R3: all mode bits, bit 7 masked
        {8'h50, 8'h40, 8'h40},   // R2 parity sense alone
        {8'h50, 8'h00, 8'h00},   // R2 all clear
        {8'h50, 8'h2A, 8'h2A},   // R2 alternating
        {8'h51, 8'hFF, 8'hE0},   // R4 enables only
        {8'h51, 8'h1E, 8'h00},   // R4 flag bits not writable
        {8'h30, 8'hFF, 8'h00}    // R9 unmapped
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) ev_corr = 1'b1;
        if (which == 1) ev_uncorr = 1'b1;
        if (which == 2) ev_ovf = 1'b1;
        @(posedge clk); #1;
        ev_corr = 1'b0; ev_uncorr = 1'b0; ev_ovf = 1'b0;
    endtask

    task automatic irq_at(input string req, input logic exp);
        @(negedge clk);
        check(req, {7'h0, irq}, {7'h0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h50, v); check("R1 mode reset", v, 8'h04);
        rd(8'h51, v); check("R1 event reset", v, 8'h00);
        @(negedge clk);
        check("R1 pins", {1'b0, par_even, filt_bypass, corr_dis, err_pass, coset_en, descr_dis, fifo_rst}, 8'h04);
        check("R1 irq", {7'h0, irq}, 8'h00);

        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][23:16], VEC[i][15:8]);
            rd(VEC[i][23:16], v);
            check($sformatf("R2/R4/R9 vector %0d", i), v, VEC[i][7:0]);
        end

        // R2 pin mapping
        wr(8'h50, 8'h55);
        @(negedge clk);
        check("R2 pins", {1'b0, par_even, filt_bypass, corr_dis, err_pass, coset_en, descr_dis, fifo_rst}, 8'h55);

        // R3 live status bit; R6 rising change
        @(negedge clk); status_ood = 1'b1;
        rd(8'h50, v); check("R3 status high", v, 8'hD5);
        wr(8'h50, 8'h80);
        rd(8'h50, v); check("R3 write to bit 7 ignored", v, 8'h80);
        rd(8'h51, v); check("R6 rising change", v, 8'h10);
        rd(8'h51, v); check("R7 cleared", v, 8'h00);
        @(negedge clk); status_ood = 1'b0;
        rd(8'h51, v); check("R6 falling change", v, 8'h10);

        // R5 sticky flags
        pulse(0); repeat (3) @(posedge clk);
        rd(8'h51, v); check("R5 corr", v, 8'h08);
        pulse(1);
        rd(8'h51, v); check("R5 uncorr", v, 8'h04);
        pulse(2);
        rd(8'h51, v); check("R5 ovf", v, 8'h02);
        rd(8'h51, v); check("R7 all clear", v, 8'h00);

        // R8 gating
        pulse(1);
        irq_at("R8 disabled", 1'b0);
        wr(8'h51, 8'h40);
        irq_at("R8 hec enable covers uncorr", 1'b1);
        wr(8'h51, 8'hA0);
        irq_at("R8 other enables", 1'b0);
        rd(8'h51, v); check("R8 readback", v, 8'hA4);
        pulse(2);
        irq_at("R8 ovf enabled", 1'b1);
        wr(8'h51, 8'h40);
        pulse(0);
        irq_at("R8 hec enable covers corr", 1'b1);

        // R7 event coincident with read
        @(negedge clk);
        addr = 8'h51; rd_en = 1'b1; ev_ovf = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0; ev_ovf = 1'b0;
        rd(8'h51, v); check("R7 coincident event kept", v, 8'h42);
        irq_at("R7 irq after clear", 1'b0);

        // R9 unmapped read clears nothing
        pulse(0);
        rd(8'h30, v); check("R9 unmapped read", v, 8'h00);
        rd(8'h51, v); check("R9 flag survives", v, 8'h48);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule